// File: doc/BRIEF.md
# Periodic Wake Power-Gating Sequencer

This always-on controller duty-cycles a power-gated baseband domain while a handset sits in paging standby. It runs from the always-on clock. A slow-clock enable (`tick_i`) drives all of its counting. An internal period counter fires a wake once every `PERIOD_TICKS` ticks. The controller then walks the gated domain through a fixed chain of phases and drops power again until the next wake. The chain is: PLL bring-up, core power-up, state restore, guard band, processing window, state save.

Each phase duration comes from a two-profile table. The profile is chosen by `mode_i`, which is sampled at the wake. The software profile spends ticks on restoring and saving state. It also has a long guard band. The retention profile holds state in always-powered latches, so its restore and save phases have zero length and its guard band is short. A zero-length phase is skipped with no clock spent in it. Software can cut a restore or save phase short with `done_i`, and can close the processing window early with `early_i`.

Isolation wraps every power transition. The controller also reports the number of completed wake sequences and the off-time of the last period. A wake that arrives while a sequence is still running is flagged as an overrun.

Top module: `pg_wake_seq`

## Requirements
- R1: After reset the domain is unpowered: `pll_en_o`, `pwr_en_o`, `save_o`, `restore_o`, `proc_o` and `overrun_o` are 0, `iso_o` is 1, and both statistics outputs are 0.
- R2: A wake occurs on the tick that completes every `PERIOD_TICKS` ticks after reset. The first wake is on tick number `PERIOD_TICKS`. `pll_en_o` rises on the clock edge that takes that tick and stays high until the sequence ends.
- R3: The software profile (`mode_i`=0 at the wake) runs these phases in this order: PLL (`PLL_TICKS`), power-up (`PWRUP_TICKS`), restore (`SW_RESTORE_TICKS`, `restore_o`=1), guard (`SW_GUARD_TICKS`), processing (`PROC_TICKS`, `proc_o`=1), save (`SW_SAVE_TICKS`, `save_o`=1). The domain then returns to off.
- R4: The retention profile (`mode_i`=1 at the wake) has zero-length restore and save phases and a guard of `RET_GUARD_TICKS`. Any zero-length phase is skipped without spending a clock in it, so `restore_o` and `save_o` stay 0.
- R5: `mode_i` is only sampled on the wake edge. Changing it during a sequence does not alter that sequence.
- R6: `iso_o` is 0 only in the restore, guard, processing and save phases. `pwr_en_o` rises on entry to power-up, while `iso_o` is still 1. `pwr_en_o` stays 1 for one extra clock after `iso_o` rises at the end of a sequence.
- R7: In the restore or save phase, `done_i`=1 ends the phase on that clock edge. In the processing phase, `early_i`=1 ends the window on that clock edge. In all other phases both strobes are ignored.
- R8: `wake_cnt_o` increments by one on the edge where a sequence returns to off.
- R9: On each wake, `off_ticks_o` is loaded with the number of ticks of the period just ended in which the domain was off. The wake tick itself counts toward the ending period.
- R10: A wake that arrives while a sequence is active sets `overrun_o`, which stays set until reset. The running sequence continues unchanged and no new sequence starts.
- R11: `save_o` is only ever high while `iso_o` is 0 and `pwr_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow-clock tick enable; all phase and period counting advances on it |
| mode_i | input | 1 | Profile select sampled at wake: 0 software save/restore, 1 retention latches |
| done_i | input | 1 | Ends the restore or save phase early |
| early_i | input | 1 | Ends the processing window early |
| pll_en_o | output | 1 | PLL enable, high for the whole active sequence |
| pwr_en_o | output | 1 | Power-switch enable for the gated domain |
| iso_o | output | 1 | Isolation clamp enable, high while the domain may be unpowered |
| save_o | output | 1 | State save phase in progress |
| restore_o | output | 1 | State restore phase in progress |
| proc_o | output | 1 | Processing window open |
| overrun_o | output | 1 | Sticky flag: a wake arrived during an active sequence |
| wake_cnt_o | output | CNT_W | Number of completed wake sequences |
| off_ticks_o | output | clog2(PERIOD_TICKS+1) | Off ticks in the last completed period |

## Verification
The bench drives the same strobes into two instances. One has a period long enough for a full sequence. The other has a period shorter than a sequence, so overrun has to occur. If a design restarted on that wake, its phase trace would diverge from the model at once. A design that leaves an unsynchronised counter running would show up in the later wake count.

The retention profile checks zero-length skipping. A design that spent a clock in a skipped phase would report different off ticks and a later processing window. `mode_i` is flipped mid-sequence to catch a design that reads the profile live. Done and early strobes arrive both inside and outside the phases they govern, and both on and between ticks. An edge-qualified or tick-qualified implementation would misplace the phase ends.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_PLL     = 3'd1,
    PH_PWRUP   = 3'd2,
    PH_RESTORE = 3'd3,
    PH_GUARD   = 3'd4,
    PH_PROC    = 3'd5,
    PH_SAVE    = 3'd6
  } phase_e;

  localparam int NPH = 7;

  // domain supply is on in these phases
  function automatic logic phase_powered(phase_e p);
    return (p == PH_PWRUP) || (p == PH_RESTORE) || (p == PH_GUARD) ||
           (p == PH_PROC)  || (p == PH_SAVE);
  endfunction

  // isolation clamps released only in these phases
  function automatic logic phase_connected(phase_e p);
    return (p == PH_RESTORE) || (p == PH_GUARD) || (p == PH_PROC) || (p == PH_SAVE);
  endfunction

endpackage

// File: rtl/pg_period_timer.sv
module pg_period_timer #(
  parameter int PERIOD_TICKS = 40960,
  localparam int PW = $clog2(PERIOD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic wake_o
);
  logic [PW-1:0] cnt_q;
  localparam logic [PW-1:0] LAST = PW'(PERIOD_TICKS - 1);

  assign wake_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wake_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pg_dur_table.sv
module pg_dur_table import pg_pkg::*; #(
  parameter int DW               = 12,
  parameter int PLL_TICKS        = 4,
  parameter int PWRUP_TICKS      = 1,
  parameter int SW_RESTORE_TICKS = 328,
  parameter int SW_GUARD_TICKS   = 3277,
  parameter int PROC_TICKS       = 655,
  parameter int SW_SAVE_TICKS    = 328,
  parameter int RET_GUARD_TICKS  = 4
) (
  input  logic          ret_i,
  input  phase_e        cur_i,
  output logic [DW-1:0] dur_o,
  output phase_e        nxt_o
);
  logic [DW-1:0] dur_tab [NPH];
  phase_e        nxt_tab [NPH];

  always_comb begin
    dur_tab[PH_OFF]     = '0;
    dur_tab[PH_PLL]     = DW'(PLL_TICKS);
    dur_tab[PH_PWRUP]   = DW'(PWRUP_TICKS);
    dur_tab[PH_RESTORE] = ret_i ? '0 : DW'(SW_RESTORE_TICKS);
    dur_tab[PH_GUARD]   = ret_i ? DW'(RET_GUARD_TICKS) : DW'(SW_GUARD_TICKS);
    dur_tab[PH_PROC]    = DW'(PROC_TICKS);
    dur_tab[PH_SAVE]    = ret_i ? '0 : DW'(SW_SAVE_TICKS);
  end

  // successor of each phase: first later phase with a nonzero length
  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      nxt_tab[p] = PH_OFF;
      for (int q = NPH - 1; q > p; q--) begin
        if (dur_tab[q] != '0) nxt_tab[p] = phase_e'(q);
      end
    end
  end

  assign dur_o = dur_tab[cur_i];
  assign nxt_o = nxt_tab[cur_i];
endmodule

// File: rtl/pg_stats.sv
module pg_stats #(
  parameter int PW    = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wake_i,
  input  logic             off_i,
  input  logic             seq_done_i,
  output logic [CNT_W-1:0] wake_cnt_o,
  output logic [PW-1:0]    off_ticks_o
);
  logic [PW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      off_ticks_o <= '0;
      wake_cnt_o  <= '0;
    end else begin
      if (wake_i) begin
        off_ticks_o <= acc_q + PW'(off_i);
        acc_q       <= '0;
      end else if (tick_i) begin
        acc_q <= acc_q + PW'(off_i);
      end
      if (seq_done_i) wake_cnt_o <= wake_cnt_o + 1'b1;
    end
  end

  a_r8_wake_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wake_cnt_o) |-> wake_cnt_o == $past(wake_cnt_o) + 1'b1);
endmodule

// File: rtl/pg_wake_seq.sv
module pg_wake_seq import pg_pkg::*; #(
  parameter int PERIOD_TICKS     = 40960,
  parameter int PLL_TICKS        = 4,
  parameter int PWRUP_TICKS      = 1,
  parameter int SW_RESTORE_TICKS = 328,
  parameter int SW_GUARD_TICKS   = 3277,
  parameter int PROC_TICKS       = 655,
  parameter int SW_SAVE_TICKS    = 328,
  parameter int RET_GUARD_TICKS  = 4,
  parameter int CNT_W            = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick_i,
  input  logic                                mode_i,
  input  logic                                done_i,
  input  logic                                early_i,
  output logic                                pll_en_o,
  output logic                                pwr_en_o,
  output logic                                iso_o,
  output logic                                save_o,
  output logic                                restore_o,
  output logic                                proc_o,
  output logic                                overrun_o,
  output logic [CNT_W-1:0]                    wake_cnt_o,
  output logic [$clog2(PERIOD_TICKS+1)-1:0]   off_ticks_o
);
  localparam int PW = $clog2(PERIOD_TICKS + 1);
  localparam int M1 = (PLL_TICKS > PWRUP_TICKS) ? PLL_TICKS : PWRUP_TICKS;
  localparam int M2 = (SW_RESTORE_TICKS > SW_GUARD_TICKS) ? SW_RESTORE_TICKS : SW_GUARD_TICKS;
  localparam int M3 = (PROC_TICKS > SW_SAVE_TICKS) ? PROC_TICKS : SW_SAVE_TICKS;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int M5 = (M3 > RET_GUARD_TICKS) ? M3 : RET_GUARD_TICKS;
  localparam int MAXD = (M4 > M5) ? M4 : M5;
  localparam int DW = $clog2(MAXD + 1);

  phase_e        phase_q, nxt;
  logic [DW-1:0] cnt_q, dur_cur;
  logic          ret_q, ret_sel, wake, ended, seq_done, pwr_prev_q, ovr_q;

  pg_period_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wake_o(wake)
  );

  // profile comes live from mode_i only while off, latched otherwise
  assign ret_sel = (phase_q == PH_OFF) ? mode_i : ret_q;

  pg_dur_table #(
    .DW(DW), .PLL_TICKS(PLL_TICKS), .PWRUP_TICKS(PWRUP_TICKS),
    .SW_RESTORE_TICKS(SW_RESTORE_TICKS), .SW_GUARD_TICKS(SW_GUARD_TICKS),
    .PROC_TICKS(PROC_TICKS), .SW_SAVE_TICKS(SW_SAVE_TICKS),
    .RET_GUARD_TICKS(RET_GUARD_TICKS)
  ) u_table (
    .ret_i(ret_sel), .cur_i(phase_q), .dur_o(dur_cur), .nxt_o(nxt)
  );

  assign ended = (phase_q != PH_OFF) &&
                 ((tick_i && (cnt_q == dur_cur - 1'b1)) ||
                  (done_i && ((phase_q == PH_RESTORE) || (phase_q == PH_SAVE))) ||
                  (early_i && (phase_q == PH_PROC)));
  assign seq_done = ended && (nxt == PH_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_OFF;
      cnt_q      <= '0;
      ret_q      <= 1'b0;
      ovr_q      <= 1'b0;
      pwr_prev_q <= 1'b0;
    end else begin
      pwr_prev_q <= phase_powered(phase_q);
      if (phase_q == PH_OFF) begin
        if (wake) begin
          phase_q <= nxt;
          cnt_q   <= '0;
          ret_q   <= mode_i;
        end
      end else begin
        if (wake) ovr_q <= 1'b1;
        if (ended) begin
          phase_q <= nxt;
          cnt_q   <= '0;
        end else if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  pg_stats #(.PW(PW), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wake_i(wake),
    .off_i(phase_q == PH_OFF), .seq_done_i(seq_done),
    .wake_cnt_o(wake_cnt_o), .off_ticks_o(off_ticks_o)
  );

  assign pll_en_o  = (phase_q != PH_OFF);
  assign pwr_en_o  = phase_powered(phase_q) || pwr_prev_q;
  assign iso_o     = !phase_connected(phase_q);
  assign save_o    = (phase_q == PH_SAVE);
  assign restore_o = (phase_q == PH_RESTORE);
  assign proc_o    = (phase_q == PH_PROC);
  assign overrun_o = ovr_q;

  a_r6_iso_when_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_o |-> iso_o);
  a_r6_power_outlasts_iso: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_o) |-> pwr_en_o);
  a_r11_save_connected: assert property (@(posedge clk) disable iff (!rst_n)
    save_o |-> (!iso_o && pwr_en_o));
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  a_r5_profile_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_OFF) && $past(phase_q != PH_OFF) |-> $stable(ret_q));
  a_r7_early_closes_window: assert property (@(posedge clk) disable iff (!rst_n)
    (early_i && phase_q == PH_PROC) |=> (phase_q != PH_PROC));
endmodule

// File: tb/sim_pg_wake_seq.sv
`timescale 1ns/1ps
module pg_ref #(
  parameter int PERIOD = 40, parameter int PLL = 2, parameter int PWRUP = 1,
  parameter int SWR = 3, parameter int SWG = 5, parameter int PROC = 4,
  parameter int SWS = 3, parameter int RETG = 1
) (
  input logic clk, input logic rst_n, input logic tick, input logic mode,
  input logic done, input logic early
);
  // phases: 0 off, 1 pll, 2 powerup, 3 restore, 4 guard, 5 proc, 6 save
  int ph, cnt, pc, acc, last_off, wcnt, prof, prevp;
  bit ovr;

  function automatic int dur(int p, int r);
    case (p)
      1: return PLL;  2: return PWRUP;
      3: return r ? 0 : SWR;  4: return r ? RETG : SWG;
      5: return PROC; 6: return r ? 0 : SWS;
      default: return 0;
    endcase
  endfunction

  function automatic int after(int p, int r);
    for (int q = p + 1; q <= 6; q++) if (dur(q, r) != 0) return q;
    return 0;
  endfunction

  function automatic bit pw(int p); return p >= 2; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; pc = 0; acc = 0; last_off = 0; wcnt = 0; prof = 0;
      prevp = 0; ovr = 0;
    end else begin
      bit wake, fin;
      int old;
      old = ph;
      wake = tick && (pc == PERIOD - 1);
      if (tick) pc = wake ? 0 : pc + 1;
      if (wake) begin last_off = acc + (old == 0); acc = 0; end
      else if (tick) acc = acc + (old == 0);
      if (old == 0) begin
        if (wake) begin prof = mode; ph = after(0, prof); cnt = 0; end
      end else begin
        if (wake) ovr = 1;
        fin = (tick && cnt == dur(old, prof) - 1) ||
              (done && (old == 3 || old == 6)) || (early && old == 5);
        if (fin) begin
          ph = after(old, prof); cnt = 0;
          if (ph == 0) wcnt++;
        end else if (tick) cnt++;
      end
      prevp = pw(old);
    end
  end

  function automatic int e_pll();  return ph != 0; endfunction
  function automatic int e_pwr();  return pw(ph) || prevp; endfunction
  function automatic int e_iso();  return !(ph >= 3); endfunction
endmodule

module sim_pg_wake_seq;
  logic clk = 0, rst_n = 0, tick = 0, mode = 0, done = 0, early = 0;
  always #2 clk = ~clk;

  logic pll0, pwr0, iso0, sv0, rs0, pr0, ov0; logic [15:0] wc0; logic [5:0] off0;
  logic pll1, pwr1, iso1, sv1, rs1, pr1, ov1; logic [15:0] wc1; logic [3:0] off1;

  pg_wake_seq #(.PERIOD_TICKS(40), .PLL_TICKS(2), .PWRUP_TICKS(1), .SW_RESTORE_TICKS(3),
    .SW_GUARD_TICKS(5), .PROC_TICKS(4), .SW_SAVE_TICKS(3), .RET_GUARD_TICKS(1)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .done_i(done), .early_i(early),
    .pll_en_o(pll0), .pwr_en_o(pwr0), .iso_o(iso0), .save_o(sv0), .restore_o(rs0),
    .proc_o(pr0), .overrun_o(ov0), .wake_cnt_o(wc0), .off_ticks_o(off0));
  pg_wake_seq #(.PERIOD_TICKS(10), .PLL_TICKS(2), .PWRUP_TICKS(1), .SW_RESTORE_TICKS(3),
    .SW_GUARD_TICKS(5), .PROC_TICKS(4), .SW_SAVE_TICKS(3), .RET_GUARD_TICKS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .done_i(done), .early_i(early),
    .pll_en_o(pll1), .pwr_en_o(pwr1), .iso_o(iso1), .save_o(sv1), .restore_o(rs1),
    .proc_o(pr1), .overrun_o(ov1), .wake_cnt_o(wc1), .off_ticks_o(off1));

  pg_ref #(.PERIOD(40)) m0 (.clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .done(done), .early(early));
  pg_ref #(.PERIOD(10)) m1 (.clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .done(done), .early(early));

  int checks = 0, fails = 0, cyc = 0, ntick = 0;
  bit rnd = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check("R2 u0 pll_en", pll0, m0.e_pll());     check("R6 u0 pwr_en", pwr0, m0.e_pwr());
    check("R6 u0 iso", iso0, m0.e_iso());        check("R3 R4 u0 restore", rs0, m0.ph == 3);
    check("R11 u0 save", sv0, m0.ph == 6);       check("R5 R7 u0 proc", pr0, m0.ph == 5);
    check("R10 u0 overrun", ov0, m0.ovr);        check("R8 u0 wake_cnt", wc0, m0.wcnt);
    check("R9 u0 off_ticks", off0, m0.last_off);
    check("R2 u1 pll_en", pll1, m1.e_pll());     check("R6 u1 pwr_en", pwr1, m1.e_pwr());
    check("R6 u1 iso", iso1, m1.e_iso());        check("R3 u1 restore", rs1, m1.ph == 3);
    check("R11 u1 save", sv1, m1.ph == 6);       check("R7 u1 proc", pr1, m1.ph == 5);
    check("R10 u1 overrun", ov1, m1.ovr);        check("R8 u1 wake_cnt", wc1, m1.wcnt);
    check("R9 u1 off_ticks", off1, m1.last_off);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    cyc++;
    tick = (cyc % 3 == 0);
    if (tick) ntick++;
    if (rnd) begin
      mode  = 1'($urandom % 2);
      done  = ($urandom % 5) == 0;
      early = ($urandom % 7) == 0;
    end
  endtask

  task automatic run_until(input int k);
    while (ntick < k) step();
    step();
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pll_en", pll0, 0); check("R1 pwr_en", pwr0, 0); check("R1 iso", iso0, 1);
    check("R1 overrun", ov0, 0); check("R1 wake_cnt", wc0, 0); check("R1 off_ticks", off0, 0);
    run_until(25);
    check("R10 u1 overrun after short period", ov1, 1);
    check("R10 u0 no overrun", ov0, 0);
    run_until(39);
    check("R2 pll_en before wake", pll0, 0);
    run_until(40);
    check("R2 pll_en on wake", pll0, 1);
    check("R9 first period all off", off0, 40);
    run_until(45);
    check("R3 restore phase", rs0, 1);
    check("R6 iso released", iso0, 0);
    run_until(85);
    check("R3 sw period off ticks", off0, 22);
    check("R8 one sequence done", wc0, 1);
    mode = 1;                           // flipped mid-sequence 2
    run_until(125);
    check("R5 mid-sequence mode ignored", off0, 22);
    check("R4 retention proc open", pr0, 1);
    check("R4 retention no restore", rs0, 0);
    run_until(165);
    check("R4 retention off ticks", off0, 32);
    check("R8 three sequences done", wc0, 3);
    rnd = 1;
    repeat (3000) step();
    rnd = 0; done = 0; early = 0;
    repeat (200) step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule